// File: doc/BRIEF.md
# Core Clock Ratio Change Sequencer

This block is the power-management controller that moves the CPU core to a new PLL ratio while the platform clock keeps running, and that also brings the core back from deep sleep. Software starts a ratio change with a one-cycle request strobe. The block then forces every peripheral clock gate shut and waits for the sleep-style quiesce to be acknowledged. It isolates the core complex outputs, holds the core in warm reset and programs the PLL with the new ratio. Once the PLL reports lock it releases the reset and then the isolation, reopens the clocks and records the outcome in its status outputs.

During a ratio change, core power stays on and the core inputs stay un-isolated. A deep-sleep wake uses the same target-ratio input and the same lock handshake. It also sequences the pads: pad inputs can come back as soon as the wake event is seen, and pad outputs stay tristated until a programmable reset counter runs out.

States: `ST_IDLE`, `ST_QUIESCE`, `ST_ISOLATE`, `ST_RELOCK`, `ST_UNRESET` (ratio change) and `ST_SLEEP`, `ST_WAKE_PLL`, `ST_WAKE_LOCK`, `ST_WAKE_UNRST`, `ST_PAD_HOLD` (deep sleep). The transitions are:
- `ST_IDLE` goes to `ST_QUIESCE` on a change request and to `ST_SLEEP` on a sleep request.
- `ST_QUIESCE` goes to `ST_ISOLATE` on the quiesce acknowledge.
- `ST_ISOLATE` goes to `ST_RELOCK` unconditionally.
- `ST_RELOCK` goes to `ST_UNRESET` on lock.
- `ST_UNRESET` goes to `ST_IDLE` unconditionally.
- `ST_SLEEP` goes to `ST_WAKE_PLL` on the wake event.
- `ST_WAKE_PLL` goes to `ST_WAKE_LOCK` unconditionally.
- `ST_WAKE_LOCK` goes to `ST_WAKE_UNRST` on lock.
- `ST_WAKE_UNRST` goes to `ST_PAD_HOLD` unconditionally.
- `ST_PAD_HOLD` goes to `ST_IDLE` when the counter reaches zero.

Top module: `core_ratio_seq`

## Requirements
- R1: After reset the block is idle. In that state:
    - `power_en_o`, `pad_in_en_o` and `pad_out_en_o` are 1.
    - Isolation, core reset, `pll_load_o`, `jog_active_o`, `done_o` and both reset-cause bits are 0.
    - `pclk_gate_o` equals `pclk_dis_cfg_i`.
    - `pll_ratio_o` and `sts_ratio_o` both equal `por_ratio_i`.
- R2: A `jog_req_i` pulse sampled in idle makes `jog_active_o` read 1 from the next cycle until the sequence ends. While it reads 1, `pclk_gate_o` is all ones whatever `pclk_dis_cfg_i` holds.
- R3: During a ratio change, `power_en_o` stays 1 and `core_in_iso_o` stays 0. `core_out_iso_o` and `core_rst_o` stay 0 until `quiesce_ack_i` is sampled high, and both read 1 in the next cycle.
- R4: In that next cycle, `pll_load_o` is 1 for exactly one cycle. `pll_ratio_o` then equals the `new_ratio_i` value sampled with the accepted request, even if `new_ratio_i` has changed since.
- R5: `core_rst_o` stays 1 until `pll_lock_i` is sampled high after the PLL has been programmed. It reads 0 in the following cycle, while `core_out_iso_o` is still 1.
- R6: One cycle after `core_rst_o` falls, several things change together:
    - `core_out_iso_o` returns to 0 and `jog_active_o` falls.
    - `pclk_gate_o` returns to `pclk_dis_cfg_i`.
    - `sts_ratio_o` takes the new ratio.
    - `rst_by_jog_o` reads 1 and `rst_by_wake_o` reads 0.

  `sts_ratio_o` does not change before that cycle.
- R7: A `jog_req_i` or `dslp_req_i` arriving while a sequence is running is ignored. No second sequence follows.
- R8: `done_o` is set when a ratio change completes and holds until a `done_clr_i` pulse clears it. A completion in the same cycle as a clear wins.
- R9: A `dslp_req_i` pulse sampled in idle enters deep sleep: `power_en_o` 0, both isolations 1, `core_rst_o` 1, pads disabled, gates all ones. If `jog_req_i` arrives in the same cycle, the ratio change wins.
- R10: A `wake_evt_i` sampled in deep sleep has these effects:
    - `new_ratio_i` is latched.
    - `power_en_o` reads 1 and `pll_load_o` pulses in the next cycle.
    - The lock wait and the ordered release of reset and isolation then follow as in R5 and R6.
- R11: With `fast_pad_i`=1, `pad_in_en_o` reads 1 from the cycle after the wake event is sampled. With `fast_pad_i`=0, it stays 0 until the pad outputs are released.
- R12: Once the isolation is released on a wake, `pad_out_en_o` stays 0 for `rst_cnt_init_i`+1 cycles and then reads 1. At that same point:
    - `sts_ratio_o` takes the new ratio.
    - `rst_by_wake_o` reads 1 and `rst_by_jog_o` reads 0.
    - `done_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Platform clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jog_req_i | input | 1 | Ratio-change request strobe (software write of the request bit) |
| dslp_req_i | input | 1 | Deep-sleep entry request strobe |
| wake_evt_i | input | 1 | Wake event while in deep sleep |
| fast_pad_i | input | 1 | Enable pad inputs at the wake event |
| done_clr_i | input | 1 | Write-1 clear of the completion flag |
| new_ratio_i | input | RATIO_W | Target core ratio |
| por_ratio_i | input | RATIO_W | Ratio from power-on configuration |
| pclk_dis_cfg_i | input | NPCLK | Programmed peripheral clock-disable bits |
| rst_cnt_init_i | input | CNT_W | Pad-output reset counter value |
| quiesce_ack_i | input | 1 | Quiesce completed |
| pll_lock_i | input | 1 | Core PLL lock |
| pclk_gate_o | output | NPCLK | Effective peripheral clock-disable bits |
| core_out_iso_o | output | 1 | Isolate core complex outputs |
| core_in_iso_o | output | 1 | Isolate core complex inputs |
| core_rst_o | output | 1 | Core warm reset |
| power_en_o | output | 1 | Core power enable |
| pll_load_o | output | 1 | Load strobe for the PLL ratio |
| pll_ratio_o | output | RATIO_W | Ratio presented to the PLL |
| pad_in_en_o | output | 1 | Pad input enable |
| pad_out_en_o | output | 1 | Pad output enable (0 = tristate) |
| jog_active_o | output | 1 | Request bit readback, self-clearing |
| done_o | output | 1 | Sticky completion flag |
| sts_ratio_o | output | RATIO_W | Status ratio field |
| rst_by_jog_o | output | 1 | Last warm reset came from a ratio change |
| rst_by_wake_o | output | 1 | Last warm reset came from a deep-sleep wake |

## Verification
Ratio changes are run with zero and non-zero delays on both the quiesce acknowledge and the PLL lock. This separates a machine that waits on each handshake from one that advances on a timer or passes a high lock straight through. The target ratio input is changed after acceptance, which exposes a design that reads the live input instead of the latched target. Requests injected mid-sequence, and jog and sleep requests arriving together, test the ignore and priority rules. Wakes with both pad modes and with counter values of zero and larger check the ordering of pad inputs against pad outputs and the exact hold length, against expected values from bench functions over randomised ratios, gate masks and delays.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_QUIESCE    = 4'd1,
        ST_ISOLATE    = 4'd2,
        ST_RELOCK     = 4'd3,
        ST_UNRESET    = 4'd4,
        ST_SLEEP      = 4'd5,
        ST_WAKE_PLL   = 4'd6,
        ST_WAKE_LOCK  = 4'd7,
        ST_WAKE_UNRST = 4'd8,
        ST_PAD_HOLD   = 4'd9
    } crs_state_e;

endpackage

// File: rtl/crs_rst_cnt.sv
module crs_rst_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] init_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= init_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R12: an expired counter never wraps while it is still being run
    a_r12_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
    import crs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic jog_req_i,
    input  logic dslp_req_i,
    input  logic wake_i,
    input  logic qack_i,
    input  logic lock_i,
    input  logic cnt_zero_i,
    input  logic fast_pad_i,
    output logic gate_all_o,
    output logic out_iso_o,
    output logic in_iso_o,
    output logic core_rst_o,
    output logic power_en_o,
    output logic pll_load_o,
    output logic pad_in_en_o,
    output logic pad_out_en_o,
    output logic jog_active_o,
    output logic cnt_load_o,
    output logic cnt_run_o,
    output logic acc_o,
    output logic fin_jog_o,
    output logic fin_wake_o
);

    crs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (jog_req_i) begin
                    state_d = ST_QUIESCE;
                end else if (dslp_req_i) begin
                    state_d = ST_SLEEP;
                end
            end
            ST_QUIESCE:    if (qack_i) state_d = ST_ISOLATE;
            ST_ISOLATE:    state_d = ST_RELOCK;
            ST_RELOCK:     if (lock_i) state_d = ST_UNRESET;
            ST_UNRESET:    state_d = ST_IDLE;
            ST_SLEEP:      if (wake_i) state_d = ST_WAKE_PLL;
            ST_WAKE_PLL:   state_d = ST_WAKE_LOCK;
            ST_WAKE_LOCK:  if (lock_i) state_d = ST_WAKE_UNRST;
            ST_WAKE_UNRST: state_d = ST_PAD_HOLD;
            ST_PAD_HOLD:   if (cnt_zero_i) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        gate_all_o   = 1'b1;
        out_iso_o    = 1'b0;
        in_iso_o     = 1'b0;
        core_rst_o   = 1'b0;
        power_en_o   = 1'b1;
        pll_load_o   = 1'b0;
        pad_in_en_o  = 1'b1;
        pad_out_en_o = 1'b1;
        jog_active_o = 1'b0;
        cnt_load_o   = 1'b0;
        cnt_run_o    = 1'b0;
        acc_o        = 1'b0;
        fin_jog_o    = 1'b0;
        fin_wake_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                gate_all_o = 1'b0;
                acc_o      = jog_req_i || dslp_req_i;
            end
            ST_QUIESCE: begin
                jog_active_o = 1'b1;
            end
            ST_ISOLATE: begin
                jog_active_o = 1'b1;
                out_iso_o    = 1'b1;
                core_rst_o   = 1'b1;
                pll_load_o   = 1'b1;
            end
            ST_RELOCK: begin
                jog_active_o = 1'b1;
                out_iso_o    = 1'b1;
                core_rst_o   = 1'b1;
            end
            ST_UNRESET: begin
                jog_active_o = 1'b1;
                out_iso_o    = 1'b1;
                fin_jog_o    = 1'b1;
            end
            ST_SLEEP: begin
                out_iso_o    = 1'b1;
                in_iso_o     = 1'b1;
                core_rst_o   = 1'b1;
                power_en_o   = 1'b0;
                pad_in_en_o  = 1'b0;
                pad_out_en_o = 1'b0;
                acc_o        = wake_i;
            end
            ST_WAKE_PLL: begin
                out_iso_o    = 1'b1;
                in_iso_o     = 1'b1;
                core_rst_o   = 1'b1;
                pll_load_o   = 1'b1;
                pad_in_en_o  = fast_pad_i;
                pad_out_en_o = 1'b0;
            end
            ST_WAKE_LOCK: begin
                out_iso_o    = 1'b1;
                in_iso_o     = 1'b1;
                core_rst_o   = 1'b1;
                pad_in_en_o  = fast_pad_i;
                pad_out_en_o = 1'b0;
            end
            ST_WAKE_UNRST: begin
                out_iso_o    = 1'b1;
                in_iso_o     = 1'b1;
                pad_in_en_o  = fast_pad_i;
                pad_out_en_o = 1'b0;
                cnt_load_o   = 1'b1;
            end
            ST_PAD_HOLD: begin
                gate_all_o   = 1'b0;
                pad_in_en_o  = fast_pad_i;
                pad_out_en_o = 1'b0;
                cnt_run_o    = 1'b1;
                fin_wake_o   = cnt_zero_i;
            end
            default: begin
                gate_all_o = 1'b0;
            end
        endcase
    end

    // R3: core stays powered with inputs open for the whole ratio change
    a_r3_power_kept: assert property (@(posedge clk) disable iff (!rst_n)
        jog_active_o |-> (power_en_o && !in_iso_o));

    // R3: output isolation during a ratio change rises only after the acknowledge
    a_r3_iso_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_iso_o) && jog_active_o) |-> $past(qack_i));

    // R5: reset is released only after lock was sampled
    a_r5_lock_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> $past(lock_i));

    // R5: isolation still held when reset falls
    a_r5_iso_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> out_iso_o);

    // R6: isolation drops one cycle after reset
    a_r6_iso_late: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |=> !out_iso_o);

    // R11: pad outputs never drive while pad inputs are off
    a_r11_pad_order: assert property (@(posedge clk) disable iff (!rst_n)
        pad_out_en_o |-> pad_in_en_o);

endmodule

// File: rtl/crs_status.sv
module crs_status #(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] por_ratio_i,
    input  logic [RATIO_W-1:0] new_ratio_i,
    input  logic               acc_i,
    input  logic               fin_jog_i,
    input  logic               fin_wake_i,
    input  logic               done_clr_i,
    output logic [RATIO_W-1:0] tgt_ratio_o,
    output logic [RATIO_W-1:0] sts_ratio_o,
    output logic               done_o,
    output logic               rst_jog_o,
    output logic               rst_wake_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_ratio_o <= por_ratio_i;
            sts_ratio_o <= por_ratio_i;
            done_o      <= 1'b0;
            rst_jog_o   <= 1'b0;
            rst_wake_o  <= 1'b0;
        end else begin
            if (acc_i) begin
                tgt_ratio_o <= new_ratio_i;
            end
            if (fin_jog_i || fin_wake_i) begin
                sts_ratio_o <= tgt_ratio_o;
            end
            if (fin_jog_i) begin
                done_o     <= 1'b1;
                rst_jog_o  <= 1'b1;
                rst_wake_o <= 1'b0;
            end else begin
                if (done_clr_i) begin
                    done_o <= 1'b0;
                end
                if (fin_wake_i) begin
                    rst_jog_o  <= 1'b0;
                    rst_wake_o <= 1'b1;
                end
            end
        end
    end

    // R6: status ratio moves only at a completion
    a_r6_sts_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(fin_jog_i || fin_wake_i) |=> $stable(sts_ratio_o));

    // R8: completion flag rises only from a finished ratio change
    a_r8_done_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(fin_jog_i));

    // R8: clear without completion drops the flag
    a_r8_done_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr_i && !fin_jog_i) |=> !done_o);

endmodule

// File: rtl/core_ratio_seq.sv
module core_ratio_seq #(
    parameter int RATIO_W = 6,
    parameter int NPCLK   = 8,
    parameter int CNT_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               jog_req_i,
    input  logic               dslp_req_i,
    input  logic               wake_evt_i,
    input  logic               fast_pad_i,
    input  logic               done_clr_i,
    input  logic [RATIO_W-1:0] new_ratio_i,
    input  logic [RATIO_W-1:0] por_ratio_i,
    input  logic [NPCLK-1:0]   pclk_dis_cfg_i,
    input  logic [CNT_W-1:0]   rst_cnt_init_i,
    input  logic               quiesce_ack_i,
    input  logic               pll_lock_i,
    output logic [NPCLK-1:0]   pclk_gate_o,
    output logic               core_out_iso_o,
    output logic               core_in_iso_o,
    output logic               core_rst_o,
    output logic               power_en_o,
    output logic               pll_load_o,
    output logic [RATIO_W-1:0] pll_ratio_o,
    output logic               pad_in_en_o,
    output logic               pad_out_en_o,
    output logic               jog_active_o,
    output logic               done_o,
    output logic [RATIO_W-1:0] sts_ratio_o,
    output logic               rst_by_jog_o,
    output logic               rst_by_wake_o
);

    logic gate_all;
    logic cnt_load;
    logic cnt_run;
    logic cnt_zero;
    logic acc;
    logic fin_jog;
    logic fin_wake;

    crs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .jog_req_i    (jog_req_i),
        .dslp_req_i   (dslp_req_i),
        .wake_i       (wake_evt_i),
        .qack_i       (quiesce_ack_i),
        .lock_i       (pll_lock_i),
        .cnt_zero_i   (cnt_zero),
        .fast_pad_i   (fast_pad_i),
        .gate_all_o   (gate_all),
        .out_iso_o    (core_out_iso_o),
        .in_iso_o     (core_in_iso_o),
        .core_rst_o   (core_rst_o),
        .power_en_o   (power_en_o),
        .pll_load_o   (pll_load_o),
        .pad_in_en_o  (pad_in_en_o),
        .pad_out_en_o (pad_out_en_o),
        .jog_active_o (jog_active_o),
        .cnt_load_o   (cnt_load),
        .cnt_run_o    (cnt_run),
        .acc_o        (acc),
        .fin_jog_o    (fin_jog),
        .fin_wake_o   (fin_wake)
    );

    crs_rst_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .run_i  (cnt_run),
        .init_i (rst_cnt_init_i),
        .zero_o (cnt_zero)
    );

    crs_status #(.RATIO_W(RATIO_W)) u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_ratio_i (por_ratio_i),
        .new_ratio_i (new_ratio_i),
        .acc_i       (acc),
        .fin_jog_i   (fin_jog),
        .fin_wake_i  (fin_wake),
        .done_clr_i  (done_clr_i),
        .tgt_ratio_o (pll_ratio_o),
        .sts_ratio_o (sts_ratio_o),
        .done_o      (done_o),
        .rst_jog_o   (rst_by_jog_o),
        .rst_wake_o  (rst_by_wake_o)
    );

    for (genvar g = 0; g < NPCLK; g++) begin : g_gate
        assign pclk_gate_o[g] = gate_all | pclk_dis_cfg_i[g];
    end

    // R2: every peripheral clock stopped while a ratio change runs
    a_r2_gate_forced: assert property (@(posedge clk) disable iff (!rst_n)
        jog_active_o |-> (pclk_gate_o == {NPCLK{1'b1}}));

    // R9: deep sleep removes power only with both isolations in place
    a_r9_iso_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !power_en_o |-> (core_in_iso_o && core_out_iso_o && core_rst_o));

endmodule

// File: tb/core_ratio_seq_tb.sv
`timescale 1ns/1ps
module core_ratio_seq_tb;

    localparam int RW = 6;
    localparam int NP = 8;
    localparam int CW = 12;
    localparam logic [RW-1:0] POR = 6'h0A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic jog_req = 1'b0, dslp_req = 1'b0, wake = 1'b0, fast_pad = 1'b0, done_clr = 1'b0;
    logic [RW-1:0] new_ratio = '0;
    logic [NP-1:0] cfg = 8'h35;
    logic [CW-1:0] cnt_init = '0;
    logic qack = 1'b0, lock = 1'b1;
    logic [NP-1:0] gate;
    logic out_iso, in_iso, core_rst, power_en, pll_load, pad_in, pad_out, jog_act, done;
    logic [RW-1:0] pll_ratio, sts_ratio;
    logic by_jog, by_wake;

    int n_chk = 0;
    int n_err = 0;
    logic [RW-1:0] exp_sts = POR;

    always #2 clk = ~clk;

    core_ratio_seq #(.RATIO_W(RW), .NPCLK(NP), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .jog_req_i(jog_req), .dslp_req_i(dslp_req),
        .wake_evt_i(wake), .fast_pad_i(fast_pad), .done_clr_i(done_clr),
        .new_ratio_i(new_ratio), .por_ratio_i(POR), .pclk_dis_cfg_i(cfg),
        .rst_cnt_init_i(cnt_init), .quiesce_ack_i(qack), .pll_lock_i(lock),
        .pclk_gate_o(gate), .core_out_iso_o(out_iso), .core_in_iso_o(in_iso),
        .core_rst_o(core_rst), .power_en_o(power_en), .pll_load_o(pll_load),
        .pll_ratio_o(pll_ratio), .pad_in_en_o(pad_in), .pad_out_en_o(pad_out),
        .jog_active_o(jog_act), .done_o(done), .sts_ratio_o(sts_ratio),
        .rst_by_jog_o(by_jog), .rst_by_wake_o(by_wake)
    );

    function automatic logic [NP-1:0] exp_gate(input logic forced, input logic [NP-1:0] c);
        return forced ? {NP{1'b1}} : c;
    endfunction

    function automatic int hold_cycles(input int n);
        return n + 1;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic jog_seq(input logic [RW-1:0] r, input logic [NP-1:0] c, input int qd,
                           input int ld, input logic extra, input logic both, input logic clr_end);
        cfg = c;
        new_ratio = r;
        lock = 1'b1;
        @(negedge clk);
        jog_req = 1'b1;
        dslp_req = both;
        @(negedge clk);
        jog_req = 1'b0;
        dslp_req = 1'b0;
        new_ratio = ~r;
        chk("R2 active", jog_act, 1);
        chk("R2 gate forced", gate, exp_gate(1'b1, c));
        chk("R9 jog priority power", power_en, 1);
        for (int i = 0; i < qd; i++) begin
            chk("R3 no iso before ack", out_iso, 0);
            chk("R3 no rst before ack", core_rst, 0);
            @(negedge clk);
        end
        qack = 1'b1;
        @(negedge clk);
        qack = 1'b0;
        lock = 1'b0;
        chk("R3 iso after ack", out_iso, 1);
        chk("R3 inputs open", in_iso, 0);
        chk("R3 power kept", power_en, 1);
        chk("R4 load pulse", pll_load, 1);
        chk("R4 latched ratio", pll_ratio, r);
        chk("R6 sts unchanged", sts_ratio, exp_sts);
        @(negedge clk);
        chk("R4 load one cycle", pll_load, 0);
        for (int i = 0; i < ld; i++) begin
            chk("R5 rst held", core_rst, 1);
            if (extra && i == 0) begin
                jog_req = 1'b1;
                dslp_req = 1'b1;
            end else begin
                jog_req = 1'b0;
                dslp_req = 1'b0;
            end
            @(negedge clk);
        end
        jog_req = 1'b0;
        dslp_req = 1'b0;
        lock = 1'b1;
        @(negedge clk);
        chk("R5 rst released", core_rst, 0);
        chk("R5 iso still held", out_iso, 1);
        chk("R2 gate still forced", gate, exp_gate(1'b1, c));
        done_clr = clr_end;
        @(negedge clk);
        done_clr = 1'b0;
        exp_sts = r;
        chk("R6 iso released", out_iso, 0);
        chk("R6 active cleared", jog_act, 0);
        chk("R6 gate restored", gate, exp_gate(1'b0, c));
        chk("R6 sts ratio", sts_ratio, r);
        chk("R6 jog cause", by_jog, 1);
        chk("R6 wake cause", by_wake, 0);
        chk("R8 done set", done, 1);
        @(negedge clk);
        chk("R7 no second seq", jog_act, 0);
        chk("R7 still powered", power_en, 1);
    endtask

    task automatic dslp_seq(input logic [RW-1:0] r, input logic [NP-1:0] c, input logic fp,
                            input int n, input int ld);
        logic done_before;
        cfg = c;
        fast_pad = fp;
        cnt_init = CW'(n);
        lock = 1'b1;
        done_before = done;
        @(negedge clk);
        dslp_req = 1'b1;
        @(negedge clk);
        dslp_req = 1'b0;
        chk("R9 power off", power_en, 0);
        chk("R9 in iso", in_iso, 1);
        chk("R9 out iso", out_iso, 1);
        chk("R9 rst", core_rst, 1);
        chk("R9 pads off", {pad_in, pad_out}, 0);
        chk("R9 gate", gate, exp_gate(1'b1, c));
        @(negedge clk);
        new_ratio = r;
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        new_ratio = ~r;
        lock = 1'b0;
        chk("R10 power on", power_en, 1);
        chk("R10 load", pll_load, 1);
        chk("R10 ratio", pll_ratio, r);
        chk("R11 pad in early", pad_in, fp);
        chk("R12 pad out held", pad_out, 0);
        @(negedge clk);
        for (int i = 0; i < ld; i++) begin
            chk("R10 rst held", core_rst, 1);
            @(negedge clk);
        end
        lock = 1'b1;
        @(negedge clk);
        chk("R10 rst released", core_rst, 0);
        chk("R10 iso held", out_iso, 1);
        for (int i = 0; i < hold_cycles(n); i++) begin
            @(negedge clk);
            chk("R10 iso released", out_iso, 0);
            chk("R12 pad out tristate", pad_out, 0);
            chk("R11 pad in", pad_in, fp);
            chk("R12 gate cfg", gate, exp_gate(1'b0, c));
            chk("R12 sts unchanged", sts_ratio, exp_sts);
        end
        @(negedge clk);
        exp_sts = r;
        chk("R12 pad out", pad_out, 1);
        chk("R11 pad in final", pad_in, 1);
        chk("R12 sts", sts_ratio, r);
        chk("R12 wake cause", by_wake, 1);
        chk("R12 jog cause", by_jog, 0);
        chk("R12 done kept", done, done_before);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4321);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 power", power_en, 1);
        chk("R1 iso", {out_iso, in_iso, core_rst, pll_load}, 0);
        chk("R1 pads", {pad_in, pad_out}, 2'b11);
        chk("R1 gate", gate, cfg);
        chk("R1 status", {jog_act, done, by_jog, by_wake}, 0);
        chk("R1 pll ratio", pll_ratio, POR);
        chk("R1 sts ratio", sts_ratio, POR);

        jog_seq(6'h12, 8'h0F, 0, 0, 1'b0, 1'b0, 1'b0);
        jog_seq(6'h2C, 8'hA0, 3, 4, 1'b1, 1'b0, 1'b0);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R8 done cleared", done, 0);
        @(negedge clk);
        chk("R8 done stays clear", done, 0);
        jog_seq(6'h07, 8'h55, 1, 2, 1'b0, 1'b1, 1'b1);
        dslp_seq(6'h21, 8'h3C, 1'b1, 0, 0);
        dslp_seq(6'h19, 8'hC3, 1'b0, 5, 3);

        for (int k = 0; k < 24; k++) begin
            logic [RW-1:0] r;
            logic [NP-1:0] c;
            r = RW'($urandom);
            c = NP'($urandom);
            if ($urandom_range(1, 0) == 1) begin
                jog_seq(r, c, $urandom_range(4, 0), $urandom_range(5, 0),
                        1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 1'b0);
            end else begin
                dslp_seq(r, c, 1'($urandom_range(1, 0)), $urandom_range(20, 0),
                         $urandom_range(5, 0));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule